// File: doc/BRIEF.md
# Serial Link Lane Power Sequencer

This block switches the transmit pads of a serial display link with up to four lanes on and off in a fixed order. A request carries a lane count, a direction (power up or power down) and a link mode. A legal request is accepted only while the block is idle. The block then walks one lane at a time through its power change, with a fixed step delay between lanes. The link mode sets that delay: the low-voltage-differential mode uses a step fifteen times longer than the normal serial mode.

The lane count becomes a cumulative enable mask. A power-up clears the power-down output of each enabled lane, visiting lanes in ascending order, and then precharges the common mode of the enabled lanes for a fixed time. A power-down raises the power-down output of each lane outside the mask, visiting lanes in descending order, and asserts the pad-calibration power-down. While a sequence runs, `busy_o` stands in for the trigger bit. When the sequence ends, busy drops and `done_o` rises.

Top module: `lane_pwr_seq`

## Requirements
- R1: After reset, `lane_pd_o` is 4'b1111, `precharge_o` is 0, `cal_pd_o` is 1, and `busy_o`, `done_o` and `err_o` are 0.
- R2: The lane count `lanes_i` is a binary number. A count of 1 gives mask 4'b0001, a count of 2 gives 4'b0011 and a count of 4 gives 4'b1111. Bit i of the mask is lane i.
- R3: A start while idle with any other count (0, 3, 5, 6, 7) sets `err_o` on the next clock. It leaves `lane_pd_o`, `precharge_o`, `cal_pd_o`, `busy_o` and `done_o` unchanged.
- R4: A start while `busy_o` is high is ignored. The running sequence continues exactly as if no start had arrived.
- R5: Power-up (`up_i`=1) visits lanes 0, 1, 2, 3 in that order. At step s (s=1..4), lane s-1 has its `lane_pd_o` bit cleared if it is in the mask. The step lands s*D clock edges after the accepting edge, and at most one bit changes per cycle.
- R6: Power-down (`up_i`=0) visits lanes 3, 2, 1, 0 in that order. At step s, lane 4-s has its bit set if it is outside the mask. Lanes inside the mask keep their state.
- R7: The step delay D is 15*STEP_CYC cycles when `lvds_i`=1 at acceptance, and 1*STEP_CYC cycles otherwise.
- R8: On power-up, `precharge_o` equals the mask from the fourth step edge for PRE_US*CYC_PER_US cycles, then returns to 0. It stays 0 during power-down and while idle.
- R9: An accepted power-up clears `cal_pd_o` on the accepting edge. An accepted power-down sets it on that edge.
- R10: An accepted legal request raises `busy_o` and clears `done_o` and `err_o` on the accepting edge. At the end of the sequence, `busy_o` falls and `done_o` rises on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request trigger, sampled each clock |
| up_i | input | 1 | 1 = power up, 0 = power down |
| lvds_i | input | 1 | 1 = long step delay mode |
| lanes_i | input | 3 | Lane count (1, 2 or 4) |
| lane_pd_o | output | 4 | Per-lane pad power-down, 1 = off |
| precharge_o | output | 4 | Per-lane common-mode precharge enable |
| cal_pd_o | output | 1 | Pad-calibration power-down |
| busy_o | output | 1 | Sequence in progress (trigger readback) |
| done_o | output | 1 | Last accepted sequence completed |
| err_o | output | 1 | Last idle request had an illegal count |

## Verification
Directed requests cover every legal count in both directions and both modes. A power-up to one lane followed by a power-up to four lanes shows that lanes already on stay on. A power-down to two lanes and then to one lane shows the descending order and that lanes in the mask are spared. Illegal counts are issued from both a powered and an unpowered state, so the check sees that nothing else moves. Starts injected mid-sequence, with the opposite direction or an illegal count, must leave the running transition unchanged. Random requests from a fixed seed then compare every cycle of lane state, precharge, busy and done against a stepped model.

// File: rtl/lps_pkg.sv
package lps_pkg;
  localparam int unsigned LANES     = 4;
  localparam int unsigned CNT_W     = $clog2(LANES + 1);
  localparam int unsigned IDX_W     = $clog2(LANES);
  localparam int unsigned MULT_NORM = 1;
  localparam int unsigned MULT_LVDS = 15;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STEP,
    ST_PRE
  } lps_state_e;
endpackage

// File: rtl/lps_mask_dec.sv
module lps_mask_dec
  import lps_pkg::*;
(
  input  logic [CNT_W-1:0] lanes_i,
  output logic             legal_o,
  output logic [LANES-1:0] mask_o
);
  // legal: nonzero power of two not above lane total
  assign legal_o = (lanes_i != '0) &&
                   ((lanes_i & (lanes_i - CNT_W'(1))) == '0) &&
                   (lanes_i <= CNT_W'(LANES));

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign mask_o[i] = legal_o && (lanes_i > CNT_W'(i));
  end
endmodule

// File: rtl/lps_timer.sv
module lps_timer #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/lps_ctrl.sv
module lps_ctrl
  import lps_pkg::*;
#(
  parameter int unsigned STEP_CYC = 4,
  parameter int unsigned PRE_CYC  = 1000,
  parameter int unsigned TMR_W    = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             up_i,
  input  logic             lvds_i,
  input  logic             legal_i,
  input  logic [LANES-1:0] mask_i,
  input  logic             tmr_zero_i,
  output logic             tmr_load_o,
  output logic [TMR_W-1:0] tmr_val_o,
  output logic [LANES-1:0] lane_pd_o,
  output logic [LANES-1:0] precharge_o,
  output logic             cal_pd_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic             dir_up_o
);
  localparam logic [TMR_W-1:0] DLY_N = TMR_W'(STEP_CYC * MULT_NORM - 1);
  localparam logic [TMR_W-1:0] DLY_L = TMR_W'(STEP_CYC * MULT_LVDS - 1);
  localparam logic [TMR_W-1:0] PRE_V = TMR_W'(PRE_CYC - 1);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(LANES - 1);

  lps_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [LANES-1:0] mask_q, pd_q, pre_q;
  logic             up_q, lvds_q, cal_q, done_q, err_q;

  logic accept, acc_ok, step_now, last_idx, pre_end;

  assign accept   = start_i && (state_q == ST_IDLE);
  assign acc_ok   = accept && legal_i;
  assign step_now = (state_q == ST_STEP) && tmr_zero_i;
  assign last_idx = up_q ? (idx_q == IDX_TOP) : (idx_q == '0);
  assign pre_end  = (state_q == ST_PRE) && tmr_zero_i;

  assign tmr_load_o = acc_ok || (step_now && (!last_idx || up_q));

  always_comb begin
    if (acc_ok)                    tmr_val_o = lvds_i ? DLY_L : DLY_N;
    else if (step_now && last_idx) tmr_val_o = PRE_V;
    else                           tmr_val_o = lvds_q ? DLY_L : DLY_N;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      mask_q  <= '0;
      pd_q    <= '1;
      pre_q   <= '0;
      up_q    <= 1'b0;
      lvds_q  <= 1'b0;
      cal_q   <= 1'b1;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (acc_ok) begin
            state_q <= ST_STEP;
            mask_q  <= mask_i;
            up_q    <= up_i;
            lvds_q  <= lvds_i;
            idx_q   <= up_i ? '0 : IDX_TOP;
            cal_q   <= !up_i;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
          end else if (accept) begin
            err_q <= 1'b1;
          end
        end
        ST_STEP: begin
          if (step_now) begin
            if (up_q && mask_q[idx_q])    pd_q[idx_q] <= 1'b0;
            if (!up_q && !mask_q[idx_q])  pd_q[idx_q] <= 1'b1;
            if (last_idx) begin
              if (up_q) begin
                state_q <= ST_PRE;
                pre_q   <= mask_q;
              end else begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
              end
            end else begin
              idx_q <= up_q ? idx_q + IDX_W'(1) : idx_q - IDX_W'(1);
            end
          end
        end
        ST_PRE: begin
          if (pre_end) begin
            pre_q   <= '0;
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign lane_pd_o   = pd_q;
  assign precharge_o = pre_q;
  assign cal_pd_o    = cal_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign dir_up_o    = up_q;
endmodule

// File: rtl/lane_pwr_seq.sv
module lane_pwr_seq
  import lps_pkg::*;
#(
  parameter int unsigned STEP_CYC   = 4,
  parameter int unsigned CYC_PER_US = 10,
  parameter int unsigned PRE_US     = 100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             up_i,
  input  logic             lvds_i,
  input  logic [CNT_W-1:0] lanes_i,
  output logic [LANES-1:0] lane_pd_o,
  output logic [LANES-1:0] precharge_o,
  output logic             cal_pd_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  localparam int unsigned PRE_CYC = PRE_US * CYC_PER_US;
  localparam int unsigned DLY_MAX = STEP_CYC * MULT_LVDS;
  localparam int unsigned TMR_MAX = (PRE_CYC > DLY_MAX) ? PRE_CYC : DLY_MAX;
  localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);

  logic             legal;
  logic [LANES-1:0] mask;
  logic             tmr_load, tmr_zero, dir_up;
  logic [TMR_W-1:0] tmr_val;

  lps_mask_dec u_dec (
    .lanes_i (lanes_i),
    .legal_o (legal),
    .mask_o  (mask)
  );

  lps_timer #(.W(TMR_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  lps_ctrl #(
    .STEP_CYC (STEP_CYC),
    .PRE_CYC  (PRE_CYC),
    .TMR_W    (TMR_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .up_i        (up_i),
    .lvds_i      (lvds_i),
    .legal_i     (legal),
    .mask_i      (mask),
    .tmr_zero_i  (tmr_zero),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .lane_pd_o   (lane_pd_o),
    .precharge_o (precharge_o),
    .cal_pd_o    (cal_pd_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .dir_up_o    (dir_up)
  );
endmodule

// File: rtl/lps_checker.sv
module lps_checker
  import lps_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             up_i,
  input logic             legal_i,
  input logic             dir_up_i,
  input logic [LANES-1:0] lane_pd_i,
  input logic [LANES-1:0] precharge_i,
  input logic             cal_pd_i,
  input logic             busy_i,
  input logic             done_i,
  input logic             err_i
);
  p_one_lane_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(lane_pd_i ^ $past(lane_pd_i)) <= 1);

  p_up_no_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && dir_up_i && $past(busy_i)) |-> ((lane_pd_i & ~$past(lane_pd_i)) == '0));

  p_down_no_on_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !dir_up_i && $past(busy_i)) |-> ((~lane_pd_i & $past(lane_pd_i)) == '0));

  p_illegal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i && !legal_i) |=> (err_i && !busy_i && $stable(lane_pd_i) && $stable(cal_pd_i)));

  p_pre_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (precharge_i != '0) |-> (busy_i && dir_up_i));

  p_accept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i && legal_i) |=> (busy_i && !done_i && !err_i));

  p_cal_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i && legal_i) |=> (cal_pd_i == !$past(up_i)));

  p_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> done_i);
endmodule

bind lane_pwr_seq lps_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .up_i        (up_i),
  .legal_i     (legal),
  .dir_up_i    (dir_up),
  .lane_pd_i   (lane_pd_o),
  .precharge_i (precharge_o),
  .cal_pd_i    (cal_pd_o),
  .busy_i      (busy_o),
  .done_i      (done_o),
  .err_i       (err_o)
);

// File: tb/lane_pwr_seq_test.sv
module lane_pwr_seq_test;
  localparam int STEP_CYC = 4, CYC_PER_US = 10, PRE_US = 100;
  localparam int PRE = PRE_US * CYC_PER_US;

  logic clk = 0, rst_n = 0;
  logic start = 0, up = 0, lvds = 0;
  logic [2:0] lanes = 0;
  logic [3:0] lane_pd, pre;
  logic cal_pd, busy, done, err;

  int n_chk = 0, n_err = 0;
  logic [3:0] m_pd;
  logic m_cal, m_done, m_err;

  always #5 clk = ~clk;

  lane_pwr_seq #(.STEP_CYC(STEP_CYC), .CYC_PER_US(CYC_PER_US), .PRE_US(PRE_US)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .up_i(up), .lvds_i(lvds),
    .lanes_i(lanes), .lane_pd_o(lane_pd), .precharge_o(pre), .cal_pd_o(cal_pd),
    .busy_o(busy), .done_o(done), .err_o(err));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] mask_of(input logic [2:0] n);
    case (n)
      3'd1: return 4'b0001;
      3'd2: return 4'b0011;
      3'd4: return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic bit legal_of(input logic [2:0] n);
    return (n == 1) || (n == 2) || (n == 4);
  endfunction

  function automatic logic [3:0] exp_pd(input logic [3:0] pd0, input bit u,
                                        input logic [3:0] m, input int steps);
    logic [3:0] r = pd0;
    for (int i = 0; i < 4; i++) begin
      if (u && i < steps && m[i]) r[i] = 1'b0;
      if (!u && i >= 4 - steps && !m[i]) r[i] = 1'b1;
    end
    return r;
  endfunction

  // poke_t < 0: no mid-run start; poke_ill selects illegal count for the poke
  task automatic run_op(input bit u, input bit lv, input logic [2:0] n,
                        input int poke_t, input bit poke_ill);
    int dly, tot;
    logic [3:0] m;
    @(negedge clk);
    start = 1; up = u; lvds = lv; lanes = n;
    @(negedge clk);
    start = 0;
    if (!legal_of(n)) begin
      m_err = 1;
      chk(err == 1'b1, "R3 err", err, 1);
      chk(lane_pd == m_pd, "R3 pd", lane_pd, m_pd);
      chk(busy == 1'b0, "R3 busy", busy, 0);
      chk(cal_pd == m_cal, "R3 cal", cal_pd, m_cal);
      chk(done == m_done, "R3 done", done, m_done);
      chk(pre == 4'b0, "R3 pre", pre, 0);
      return;
    end
    m   = mask_of(n);
    dly = (lv ? 15 : 1) * STEP_CYC;
    tot = u ? 4 * dly + PRE : 4 * dly;
    m_cal = !u; m_err = 0;
    for (int t = 0; t <= tot + 1; t++) begin
      int st;
      logic [3:0] ep;
      st = (t / dly > 4) ? 4 : t / dly;
      ep = exp_pd(m_pd, u, m, st);
      chk(lane_pd == ep, u ? "R5 R7 pd" : "R6 R7 pd", lane_pd, ep);
      chk(pre == ((u && t >= 4 * dly && t < tot) ? m : 4'b0), "R8 pre", pre,
          (u && t >= 4 * dly && t < tot) ? m : 4'b0);
      chk(busy == (t < tot), "R10 busy", busy, t < tot);
      chk(done == (t >= tot), "R10 done", done, t >= tot);
      chk(cal_pd == m_cal, "R9 cal", cal_pd, m_cal);
      chk(err == 1'b0, "R10 err", err, 0);
      if (t == poke_t) begin
        start = 1; up = !u; lvds = !lv; lanes = poke_ill ? 3'd3 : 3'd4;  // R4
      end else begin
        start = 0;
      end
      @(negedge clk);
    end
    start = 0;
    m_pd = exp_pd(m_pd, u, m, 4);
    m_done = 1;
  endtask

  initial begin
    #(200000 * 10);
    n_err++; n_chk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_pd = 4'b1111; m_cal = 1; m_done = 0; m_err = 0;
    repeat (3) @(negedge clk);
    // R1
    chk(lane_pd == 4'b1111, "R1 pd", lane_pd, 4'hf);
    chk(pre == 4'b0, "R1 pre", pre, 0);
    chk(cal_pd == 1'b1, "R1 cal", cal_pd, 1);
    chk({busy, done, err} == 3'b0, "R1 flags", {busy, done, err}, 0);
    rst_n = 1;
    @(negedge clk);
    // R3 from reset state
    run_op(1, 0, 3'd0, -1, 0);
    run_op(1, 0, 3'd3, -1, 0);
    // R2 R5 one lane then four lanes, normal and long mode
    run_op(1, 0, 3'd1, -1, 0);
    run_op(1, 1, 3'd4, 30, 0);   // R4 opposite direction poke
    // R6 down to two lanes, then one, with illegal poke
    run_op(0, 0, 3'd2, 5, 1);
    run_op(0, 1, 3'd1, 70, 0);
    run_op(0, 0, 3'd7, -1, 0);
    run_op(1, 0, 3'd2, -1, 0);
    run_op(0, 0, 3'd4, -1, 0);   // R6 all lanes kept, cal asserted
    run_op(1, 0, 3'd5, -1, 0);
    for (int k = 0; k < 25; k++) begin
      logic [2:0] n;
      int r;
      r = $urandom_range(0, 9);
      n = (r < 8) ? ((r % 3 == 0) ? 3'd1 : (r % 3 == 1) ? 3'd2 : 3'd4) : 3'($urandom_range(0, 7));
      run_op(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), n,
             ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 20)) : -1,
             1'($urandom_range(0, 1)));
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule